// File: doc/BRIEF.md
# PCI Bridge Address Window Decoder

This block makes the address decisions of a host-to-PCI bridge in both directions. For CPU accesses, it looks at the top 256 MiB of the 32-bit space. That range is split into 32 segments of 8 MiB. The decoder says whether the CPU access is claimed and sent on to PCI memory. A segment is claimed only when its own enable bit is set and a 2-bit forwarding mode field in a control register is set to on. A claimed access keeps its address unchanged on the PCI side.

For bus-master accesses that arrive from PCI, the decoder puts each address into one of four classes: system memory, peer PCI memory (the same 30 segments), a 1 MiB CPU-local window at the top of the space, or unclaimed, so that the bus can master-abort.

The enable register and the control register are read and written through a simple 32-bit register port. Reads are combinational. Writes take effect on the clock edge. The decode outputs are combinational functions of the input addresses and the stored registers. The block does not run any bus transaction.

Top module: `pci_window_decode`

## Requirements
- R1: After reset, both registers read as 0 and no CPU access is claimed.
- R2: A write to offset 0x060 stores the write data ANDed with 0x7FFFFFFE into the segment enable register. Bit i of this register enables segment i. Bits 0 and 31 always read back as 0.
- R3: A write to offset 0x038 stores all 32 bits into the control register. Any other offset reads as 0, and a write to it leaves both registers unchanged.
- R4: `cpu_hit` is 1 exactly when all of these hold: cpu_addr[31:28] is 0xF; the enable bit indexed by cpu_addr[27:23] is set; control bits [8:7] equal 2'b01. Because bits 0 and 31 are forced to 0, only 0xF0800000 to 0xFF7FFFFF can ever be claimed.
- R5: `cpu_pci_addr` equals `cpu_addr` when `cpu_hit` is 1. Otherwise it is 0.
- R6: An inbound address below 0xF0800000 decodes as system memory, `bm_class` = 1.
- R7: An inbound address from 0xF0800000 to 0xFF7FFFFF decodes as PCI peer memory, `bm_class` = 2, whatever the register values are.
- R8: An inbound address from 0xFFF00000 to 0xFFFFFFFF decodes as the CPU-local window, `bm_class` = 3.
- R9: An inbound address from 0xFF800000 to 0xFFEFFFFF decodes as unclaimed, `bm_class` = 0.
- R10: A register write changes the CPU decode starting with the cycle after the clock edge that stores it. The decode in the cycle that carries the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cpu_addr | input | 32 | CPU-side access address |
| cpu_hit | output | 1 | CPU access is forwarded to PCI memory |
| cpu_pci_addr | output | 32 | Address placed on PCI for a forwarded access |
| bm_addr | input | 32 | Inbound bus-master address |
| bm_class | output | 2 | Inbound class: 0 unclaimed, 1 system, 2 peer PCI, 3 CPU-local |

## Verification
The decode outputs and the read data follow their inputs in the same cycle. The bench sets the addresses away from the clock edge and samples after a short settle delay. A register write lands on one rising edge. Its effect is therefore checked at the next falling edge, and the old decode is checked just before that edge. The bench sweeps both ends of every one of the 32 segments, under all four mode values and several enable patterns. It steps through the whole inbound space in 1 MiB steps, checking both ends of each step. Expected values come from an arithmetic model kept in the bench.

// File: rtl/pci_window_decode.sv
module pci_window_decode #(
  parameter int unsigned REG_AW      = 12,
  parameter int unsigned OFS_ENABLE  = 12'h060,
  parameter int unsigned OFS_CONTROL = 12'h038,
  parameter logic [31:0] ENABLE_MASK = 32'h7FFF_FFFE,
  parameter logic [31:0] SEG_BASE    = 32'hF000_0000,
  parameter int unsigned SEG_LOG2    = 23,
  parameter logic [31:0] LOCAL_BASE  = 32'hFFF0_0000,
  parameter int unsigned MODE_LSB    = 7,
  parameter logic [1:0]  MODE_ON     = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       cpu_addr,
  output logic              cpu_hit,
  output logic [31:0]       cpu_pci_addr,
  input  logic [31:0]       bm_addr,
  output logic [1:0]        bm_class
);
  localparam int unsigned IDX_W = 5;
  localparam logic [31:0] SEG_SIZE = 32'(1) << SEG_LOG2;
  localparam logic [31:0] PEER_LO  = SEG_BASE + SEG_SIZE;
  localparam logic [31:0] PEER_END = SEG_BASE + 32'(31) * SEG_SIZE;
  localparam logic [1:0] CL_NONE = 2'd0, CL_SYS = 2'd1, CL_PEER = 2'd2, CL_LOCAL = 2'd3;

  logic [31:0] seg_en, ctrl;
  logic [31:0] seg_off;
  logic [IDX_W-1:0] seg_idx;
  logic fwd_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_en <= '0;
      ctrl   <= '0;
    end else if (reg_we) begin
      if (reg_addr == REG_AW'(OFS_ENABLE))  seg_en <= reg_wdata & ENABLE_MASK;
      if (reg_addr == REG_AW'(OFS_CONTROL)) ctrl   <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_AW'(OFS_ENABLE))  reg_rdata = seg_en;
    if (reg_addr == REG_AW'(OFS_CONTROL)) reg_rdata = ctrl;
  end

  assign fwd_on       = (ctrl[MODE_LSB +: 2] == MODE_ON);
  assign seg_off      = cpu_addr - SEG_BASE;
  assign seg_idx      = seg_off[SEG_LOG2 +: IDX_W];
  assign cpu_hit      = fwd_on && (cpu_addr >= SEG_BASE) && seg_en[seg_idx];
  assign cpu_pci_addr = cpu_hit ? cpu_addr : '0;

  always_comb begin
    if (bm_addr < PEER_LO)        bm_class = CL_SYS;
    else if (bm_addr < PEER_END)  bm_class = CL_PEER;
    else if (bm_addr >= LOCAL_BASE) bm_class = CL_LOCAL;
    else                          bm_class = CL_NONE;
  end

  a_r4_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> (ctrl[MODE_LSB +: 2] == MODE_ON));
  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> (cpu_addr >= PEER_LO && cpu_addr < PEER_END));
  a_r5_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> (cpu_pci_addr == cpu_addr));
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_hit |-> (cpu_pci_addr == '0));
  a_r6_system: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_class == CL_SYS) |-> (bm_addr < PEER_LO));
  a_r2_edges_off: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (seg_en[0] == 1'b0 && seg_en[31] == 1'b0));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(seg_en) && $stable(ctrl)));
endmodule

// File: tb/pci_window_decode_test.sv
module pci_window_decode_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] cpu_addr = '0;
  logic        cpu_hit;
  logic [31:0] cpu_pci_addr;
  logic [31:0] bm_addr = '0;
  logic [1:0]  bm_class;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_en = '0, m_ctrl = '0;

  pci_window_decode uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .cpu_hit(cpu_hit), .cpu_pci_addr(cpu_pci_addr), .bm_addr(bm_addr),
    .bm_class(bm_class));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(logic [31:0] a);
    return (a[31:28] == 4'hF) && (m_ctrl[8:7] == 2'b01) && m_en[a[27:23]];
  endfunction

  function automatic logic [1:0] exp_class(logic [31:0] a);
    if (a < 32'hF080_0000) return 2'd1;
    if (a < 32'hFF80_0000) return 2'd2;
    if (a >= 32'hFFF0_0000) return 2'd3;
    return 2'd0;
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 12'h060) m_en = d & 32'h7FFF_FFFE;
    if (a == 12'h038) m_ctrl = d;
  endtask

  task automatic rd_check(string req, logic [11:0] a, logic [31:0] exp);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic cpu_check(logic [31:0] a);
    cpu_addr = a; #1;
    check("R4", {31'd0, cpu_hit}, {31'd0, exp_hit(a)});
    check("R5", cpu_pci_addr, exp_hit(a) ? a : 32'd0);
  endtask

  task automatic sweep_cpu();
    for (int s = 0; s < 32; s++) begin
      cpu_check(32'hF000_0000 + (32'(s) << 23));
      cpu_check(32'hF000_0000 + (32'(s) << 23) + 32'h007F_FFFF);
    end
    cpu_check(32'hEFFF_FFFF);
    cpu_check(32'h1080_0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A;
    pats[2] = 32'h8000_0003; pats[3] = 32'h4000_0002;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    rd_check("R1", 12'h060, 32'd0);
    rd_check("R1", 12'h038, 32'd0);
    cpu_addr = 32'hF080_0000; #1;
    check("R1", {31'd0, cpu_hit}, 32'd0);

    // R2: enable masking
    wr(12'h060, 32'hFFFF_FFFF);
    rd_check("R2", 12'h060, 32'h7FFF_FFFE);
    wr(12'h060, 32'h8000_0001);
    rd_check("R2", 12'h060, 32'd0);

    // R3: control full width, other offsets inert
    wr(12'h038, 32'hDEAD_BEEF);
    rd_check("R3", 12'h038, 32'hDEAD_BEEF);
    wr(12'h064, 32'h1234_5678);
    rd_check("R3", 12'h064, 32'd0);
    rd_check("R3", 12'h038, 32'hDEAD_BEEF);
    rd_check("R3", 12'h060, 32'd0);

    // R4/R5: all modes x enable patterns x every segment end
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        wr(12'h038, 32'h0000_0000 | (32'(m) << 7) | 32'hFFFF_FE7F);
        wr(12'h060, pats[p]);
        sweep_cpu();
      end
    end

    // R10: timing of a write relative to decode
    wr(12'h038, 32'h0000_0080);
    wr(12'h060, 32'd0);
    cpu_addr = 32'hF100_0000;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'h060; reg_wdata = 32'h0000_0004;
    #1;
    check("R10", {31'd0, cpu_hit}, 32'd0);
    @(negedge clk);
    reg_we = 1'b0;
    m_en = 32'h0000_0004;
    #1;
    check("R10", {31'd0, cpu_hit}, 32'd1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'h038; reg_wdata = 32'h0000_0100;
    #1;
    check("R10", {31'd0, cpu_hit}, 32'd1);
    @(negedge clk);
    reg_we = 1'b0;
    m_ctrl = 32'h0000_0100;
    #1;
    check("R10", {31'd0, cpu_hit}, 32'd0);

    // R6-R9: inbound sweep in 1 MiB steps, both ends of each step
    for (int k = 0; k < 4096; k++) begin
      for (int e = 0; e < 2; e++) begin
        logic [31:0] a;
        logic [1:0] x;
        a = (32'(k) << 20) | (e ? 32'h000F_FFFF : 32'd0);
        bm_addr = a; #1;
        x = exp_class(a);
        case (x)
          2'd1: check("R6", {30'd0, bm_class}, {30'd0, x});
          2'd2: check("R7", {30'd0, bm_class}, {30'd0, x});
          2'd3: check("R8", {30'd0, bm_class}, {30'd0, x});
          default: check("R9", {30'd0, bm_class}, {30'd0, x});
        endcase
      end
    end
    bm_addr = 32'hF07F_FFFF; #1; check("R6", {30'd0, bm_class}, 32'd1);
    bm_addr = 32'hF080_0000; #1; check("R7", {30'd0, bm_class}, 32'd2);
    bm_addr = 32'hFF7F_FFFF; #1; check("R7", {30'd0, bm_class}, 32'd2);
    bm_addr = 32'hFF80_0000; #1; check("R9", {30'd0, bm_class}, 32'd0);
    bm_addr = 32'hFFEF_FFFF; #1; check("R9", {30'd0, bm_class}, 32'd0);
    bm_addr = 32'hFFF0_0000; #1; check("R8", {30'd0, bm_class}, 32'd3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule